// File: doc/BRIEF.md
# Coarse-Fine Column Converter Digital Backend

This block is the digital half of a single-slope column converter whose least significant bits come from a phase-sampling time-to-digital stage. An analog comparator produces a pulse whose width encodes the pixel level. While the pulse is high, a coarse counter advances once per master clock period. When the pulse falls, a short, programmable sampling window keeps an 8-channel phase snapshot live for a few more cycles and then freezes it. The four primary clock phases and their four interpolated midpoints form that snapshot. The frozen snapshot is then read bit by bit under a 9-step address sequence and reduced to a 4-bit fine code.

The coarse count and the fine code together form a 12-bit raw code: 11 bits of resolution and one redundant bit. The sampling window adds a fixed number of fine steps to every raw code. Each pixel is therefore converted twice, first at its reset level and then at its signal level. The backend subtracts the reset-level code from the signal-level code and clamps the difference at zero. This removes the window offset together with any other constant offset. Comparator, ramp, delay cells and hysteresis stage are analog and lie outside this block.

In this digital model, one system clock cycle stands for one fine step, so one master clock period spans 16 cycles.

Top module: `colq_backend`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is low until the first signal-level conversion completes.
- R2: Snapshot channel order is fixed: channel 2k is `ph_main[k]` and channel 2k+1 is `ph_mid[k]`, for k = 0..3. Channel 7 is the most significant snapshot bit.
- R3: Let s be the frozen 8-bit snapshot. If s[7] is 0, the fine code equals the number of ones in s. If s[7] is 1, the fine code equals 8 plus the number of zeros in s. The range is 0..15.
- R4: The coarse counter starts at 0 on `conv_start` and steps by one on every sampled cycle in which the channel-7 phase flop goes from 1 to 0. The raw code is coarse × 16 + fine. For a phase sequence advancing one step per cycle, the raw code equals the number of sampled cycles N.
- R5: Sampling runs while `cmp_pulse` is high. It continues for exactly `win_len`+1 cycles counted from the first cycle in which the pulse is seen low, and that cycle is included. Afterwards the phase flops and the coarse counter hold, and any later phase activity has no effect on the result.
- R6: The coarse counter holds at 255 instead of wrapping. The fine code is still taken from the snapshot.
- R7: `result_valid` is high for exactly one cycle. It rises at clock edge F + `win_len` + 11, where F is the edge at which `cmp_pulse` is first sampled low after `conv_start`.
- R8: A conversion started with `conv_is_ref` = 1 stores its raw code as the reference and raises no `result_valid`. A signal conversion outputs its raw code minus the reference, clamped at 0. The reference is 0 after reset.
- R9: A `conv_start` issued while a conversion is still sampling or being decoded abandons that conversion: it produces no `result_valid`, and the new conversion starts from cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one fine step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_start | input | 1 | One-cycle pulse that clears state and arms a conversion |
| conv_is_ref | input | 1 | Sampled with `conv_start`: 1 marks a reset-level conversion |
| cmp_pulse | input | 1 | Comparator output; its high time encodes the level |
| ph_main | input | 4 | Four primary master clock phases |
| ph_mid | input | 4 | Four interpolated midpoint phases |
| win_len | input | 2 | Extra window cycles after the pulse falls (window = `win_len`+1 cycles) |
| result | output | 12 | Reference-subtracted conversion result, clamped at zero |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
Errors inside this block show up at the ports within the same conversion. A coarse count that misses a period boundary, or a snapshot bit that keeps toggling after the window, changes `result` by 16 or by a few fine steps. A misread snapshot bit during readout or a wrong decode branch shifts the fine part by a non-constant amount. Since the pulse width and window length are swept so that every one of the 16 phase codes is the final snapshot for each window length, such a fault appears as a wrong value on the next `result_valid`. A sequencer that skips or repeats an address step moves the strobe away from its fixed edge, and a stale decoder after an abort shows up as an extra strobe one to ten cycles after the new start.

// File: rtl/colq_pkg.sv
package colq_pkg;

  // Stage of the phase sampler within one conversion
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,   // snapshot frozen, waiting for a start
    FR_HIGH = 2'd1,   // armed, sampling while the comparator pulse is high
    FR_WIN  = 2'd2    // post-fall window still sampling
  } fr_state_t;

endpackage

// File: rtl/colq_phase_interp.sv
// Places primary and interpolated phases on alternating snapshot channels.
module colq_phase_interp #(
  parameter int PH_IN = 4,
  localparam int NCH  = 2 * PH_IN
) (
  input  logic [PH_IN-1:0] ph_main,
  input  logic [PH_IN-1:0] ph_mid,
  output logic [NCH-1:0]   ch
);

  for (genvar k = 0; k < PH_IN; k++) begin : g_lane
    assign ch[2*k]   = ph_main[k];
    assign ch[2*k+1] = ph_mid[k];
  end

endmodule

// File: rtl/colq_sampler.sv
// Phase flops, coarse counter and the post-fall enable window.
module colq_sampler
  import colq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int COARSE_W = 8,
  parameter int WIN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                pulse,
  input  logic [NCH-1:0]      ch,
  input  logic [WIN_W-1:0]    win_len,
  output logic [NCH-1:0]      snap,
  output logic [COARSE_W-1:0] coarse,
  output logic                snap_rdy
);

  localparam logic [COARSE_W-1:0] CMAX = '1;

  fr_state_t            st_q, st_n;
  logic                 pulse_d_q, pulse_d_n;
  logic [WIN_W-1:0]     win_q, win_n;
  logic [NCH-1:0]       ph_q, ph_n;
  logic [COARSE_W-1:0]  cnt_q, cnt_n;
  logic                 rdy_q, rdy_n;
  logic                 fall;
  logic                 en;
  logic                 wrap;

  assign fall = pulse_d_q & ~pulse;
  assign en   = ((st_q == FR_HIGH) & (pulse | fall)) | (st_q == FR_WIN);
  // Master-phase flop drops 1 -> 0 at a period boundary
  assign wrap = ph_q[NCH-1] & ~ch[NCH-1];

  always_comb begin
    st_n      = st_q;
    pulse_d_n = pulse_d_q;
    win_n     = win_q;
    ph_n      = ph_q;
    cnt_n     = cnt_q;
    rdy_n     = 1'b0;
    if (clr) begin
      st_n      = FR_HIGH;
      pulse_d_n = 1'b0;
      win_n     = '0;
      ph_n      = '0;
      cnt_n     = '0;
    end else begin
      pulse_d_n = (st_q == FR_HIGH) ? pulse : 1'b0;
      case (st_q)
        FR_HIGH: begin
          if (fall) begin
            if (win_len == '0) begin
              st_n  = FR_IDLE;
              rdy_n = 1'b1;
            end else begin
              st_n  = FR_WIN;
              win_n = win_len;
            end
          end
        end
        FR_WIN: begin
          win_n = win_q - 1'b1;
          if (win_q == WIN_W'(1)) begin
            st_n  = FR_IDLE;
            rdy_n = 1'b1;
          end
        end
        default: st_n = FR_IDLE;
      endcase
      if (en) begin
        ph_n = ch;
        if (wrap && (cnt_q != CMAX)) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FR_IDLE;
      pulse_d_q <= 1'b0;
      win_q     <= '0;
      ph_q      <= '0;
      cnt_q     <= '0;
      rdy_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      pulse_d_q <= pulse_d_n;
      win_q     <= win_n;
      ph_q      <= ph_n;
      cnt_q     <= cnt_n;
      rdy_q     <= rdy_n;
    end
  end

  assign snap     = ph_q;
  assign coarse   = cnt_q;
  assign snap_rdy = rdy_q;

  // R5: no phase flop toggles outside the sampling window
  p_frozen_outside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(snap));

  // R4: the coarse count only grows within a conversion
  p_coarse_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (coarse >= $past(coarse)));

  // R6: a full coarse counter stays full
  p_coarse_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (coarse == CMAX)) |=> (coarse == CMAX));

  // R7: the freeze marker lasts one cycle
  p_rdy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rdy |=> !snap_rdy);

endmodule

// File: rtl/colq_fine_dec.sv
// Addressed serial readout of the snapshot and popcount-style fine decode.
module colq_fine_dec #(
  parameter int NCH    = 8,
  parameter int FINE_W = 4,
  localparam int AW    = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic [NCH-1:0]    snap,
  output logic [FINE_W-1:0] fine,
  output logic              fin
);

  logic              act_q, act_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic              mode_q, mode_n;
  logic [FINE_W-1:0] acc_q, acc_n;
  logic [FINE_W-1:0] fine_q, fine_n;
  logic              fin_q, fin_n;
  logic              rd_bit;

  // Address a selects snapshot bit NCH-1-a: MSB first
  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_q == AW'(NCH - 1 - i)) rd_bit = snap[i];
    end
  end

  always_comb begin
    act_n  = act_q;
    addr_n = addr_q;
    mode_n = mode_q;
    acc_n  = acc_q;
    fine_n = fine_q;
    fin_n  = 1'b0;
    if (clr) begin
      act_n  = 1'b0;
      addr_n = '0;
      mode_n = 1'b0;
      acc_n  = '0;
    end else if (go) begin
      act_n  = 1'b1;
      addr_n = '0;
    end else if (act_q) begin
      if (addr_q == '0) begin
        mode_n = rd_bit;
        acc_n  = '0;
        addr_n = addr_q + 1'b1;
      end else if (addr_q < AW'(NCH)) begin
        acc_n  = acc_q + FINE_W'(rd_bit ^ mode_q);
        addr_n = addr_q + 1'b1;
      end else begin
        fine_n = mode_q ? (FINE_W'(NCH) + acc_q) : acc_q;
        fin_n  = 1'b1;
        act_n  = 1'b0;
        addr_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      mode_q <= 1'b0;
      acc_q  <= '0;
      fine_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      addr_q <= addr_n;
      mode_q <= mode_n;
      acc_q  <= acc_n;
      fine_q <= fine_n;
      fin_q  <= fin_n;
    end
  end

  assign fine = fine_q;
  assign fin  = fin_q;

  // R7: the address sequence never leaves its 9 steps
  p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (addr_q <= AW'(NCH)));

  // R3: upper half of the fine range iff the frozen MSB is set
  p_fine_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((fine >= FINE_W'(NCH)) == snap[NCH-1]));

endmodule

// File: rtl/colq_cds.sv
// Holds the reset-level code and forms the clamped difference.
module colq_cds #(
  parameter int RAW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic             is_ref,
  input  logic [RAW_W-1:0] raw,
  output logic [RAW_W-1:0] result,
  output logic             valid
);

  logic [RAW_W-1:0] ref_q, ref_n;
  logic [RAW_W-1:0] res_q, res_n;
  logic             vld_q, vld_n;

  always_comb begin
    ref_n = ref_q;
    res_n = res_q;
    vld_n = 1'b0;
    if (fin) begin
      if (is_ref) begin
        ref_n = raw;
      end else begin
        res_n = (raw >= ref_q) ? (raw - ref_q) : '0;
        vld_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      ref_q <= ref_n;
      res_q <= res_n;
      vld_q <= vld_n;
    end
  end

  assign result = res_q;
  assign valid  = vld_q;

  // R8: a subtracted result never exceeds the raw code it came from
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (result <= $past(raw)));

  // R7: strobe is a single cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

endmodule

// File: rtl/colq_backend.sv
module colq_backend #(
  parameter int PH_IN  = 4,
  parameter int RAW_W  = 12,
  parameter int WIN_W  = 2,
  localparam int NCH      = 2 * PH_IN,
  localparam int FINE_W   = $clog2(2 * NCH),
  localparam int COARSE_W = RAW_W - FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             conv_is_ref,
  input  logic             cmp_pulse,
  input  logic [PH_IN-1:0] ph_main,
  input  logic [PH_IN-1:0] ph_mid,
  input  logic [WIN_W-1:0] win_len,
  output logic [RAW_W-1:0] result,
  output logic             result_valid
);

  logic [1:0]          rst_pipe;
  logic                rst_core_n;
  logic                kind_ref_q, kind_ref_n;
  logic [NCH-1:0]      ch;
  logic [NCH-1:0]      snap;
  logic [COARSE_W-1:0] coarse;
  logic                snap_rdy;
  logic [FINE_W-1:0]   fine;
  logic                dec_fin;
  logic [RAW_W-1:0]    raw;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  always_comb begin
    kind_ref_n = kind_ref_q;
    if (conv_start) kind_ref_n = conv_is_ref;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) kind_ref_q <= 1'b0;
    else             kind_ref_q <= kind_ref_n;
  end

  colq_phase_interp #(.PH_IN(PH_IN)) u_interp (
    .ph_main (ph_main),
    .ph_mid  (ph_mid),
    .ch      (ch)
  );

  colq_sampler #(.NCH(NCH), .COARSE_W(COARSE_W), .WIN_W(WIN_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (conv_start),
    .pulse    (cmp_pulse),
    .ch       (ch),
    .win_len  (win_len),
    .snap     (snap),
    .coarse   (coarse),
    .snap_rdy (snap_rdy)
  );

  colq_fine_dec #(.NCH(NCH), .FINE_W(FINE_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (conv_start),
    .go    (snap_rdy),
    .snap  (snap),
    .fine  (fine),
    .fin   (dec_fin)
  );

  assign raw = {coarse, fine};

  colq_cds #(.RAW_W(RAW_W)) u_cds (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .fin    (dec_fin),
    .is_ref (kind_ref_q),
    .raw    (raw),
    .result (result),
    .valid  (result_valid)
  );

  // R7: a strobe is always preceded by the end of a decode
  p_valid_after_decode_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    result_valid |-> $past(dec_fin));

  // R8: reference conversions stay silent
  p_ref_silent_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_fin && kind_ref_q) |=> !result_valid);

  // R9: a start aborts the readout in flight
  p_start_aborts_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    conv_start |=> !dec_fin);

endmodule

// File: tb/colq_backend_test.sv
module colq_backend_test;

  logic        clk;
  logic        rst_n;
  logic        conv_start;
  logic        conv_is_ref;
  logic        cmp_pulse;
  logic [3:0]  ph_main;
  logic [3:0]  ph_mid;
  logic [1:0]  win_len;
  logic [11:0] result;
  logic        result_valid;

  int n_chk;
  int n_bad;
  int ref_raw;

  colq_backend uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start   (conv_start),
    .conv_is_ref  (conv_is_ref),
    .cmp_pulse    (cmp_pulse),
    .ph_main      (ph_main),
    .ph_mid       (ph_mid),
    .win_len      (win_len),
    .result       (result),
    .result_valid (result_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 8-bit phase code of fine step t (0..15): thermometer fill then drain
  function automatic logic [7:0] jcode(input int t);
    logic [7:0] v;
    if (t <= 8) v = 8'((9'd1 << t) - 9'd1);
    else        v = 8'(8'hFF << (t - 8));
    return v;
  endfunction

  // R2: channel 2k = main[k], channel 2k+1 = mid[k]
  task automatic drive_phase(input int t);
    logic [7:0] j;
    j = jcode(t % 16);
    for (int k = 0; k < 4; k++) begin
      ph_main[k] = j[2*k];
      ph_mid[k]  = j[2*k+1];
    end
  endtask

  // R4/R6: raw code for N sampled cycles
  function automatic int raw_of(input int n);
    int c;
    c = n / 16;
    if (c > 255) c = 255;
    return c * 16 + n % 16;
  endfunction

  // One conversion: pulse high for p cycles, window wl
  task automatic run_conv(input bit is_ref, input int p, input int wl,
                          input int exp, input string tag);
    int seen;
    int at_edge;
    int got;
    seen = 0; at_edge = -1; got = -1;
    @(negedge clk);
    conv_start  = 1'b1;
    conv_is_ref = is_ref;
    cmp_pulse   = 1'b0;
    win_len     = 2'(wl);
    drive_phase(0);
    for (int k = 1; k <= p + wl + 30; k++) begin
      @(negedge clk);
      if (result_valid) begin
        seen++;
        at_edge = k - 1;
        got = int'(result);
      end
      conv_start = 1'b0;
      cmp_pulse  = (k <= p);
      drive_phase(k);   // phases keep running after the window (R5)
    end
    if (is_ref) begin
      check({"R8 reference conversion raises no strobe ", tag}, seen, 0);
    end else begin
      check({"R7 strobe count ", tag}, seen, 1);
      check({"R7 strobe edge ", tag}, at_edge, p + wl + 12);
      check({tag, " value"}, got, exp);
    end
  endtask

  // Starts a conversion and stops right after the pulse falls (R9)
  task automatic run_partial(input int p, input int wl);
    @(negedge clk);
    conv_start  = 1'b1;
    conv_is_ref = 1'b0;
    cmp_pulse   = 1'b0;
    win_len     = 2'(wl);
    drive_phase(0);
    for (int k = 1; k <= p + 1; k++) begin
      @(negedge clk);
      conv_start = 1'b0;
      cmp_pulse  = (k <= p);
      drive_phase(k);
    end
  endtask

  task automatic set_ref(input int p, input int wl);
    ref_raw = raw_of(p + wl + 1);
    run_conv(1'b1, p, wl, 0, "ref");
  endtask

  function automatic int cds_exp(input int p, input int wl);
    int d;
    d = raw_of(p + wl + 1) - ref_raw;
    return (d < 0) ? 0 : d;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; ref_raw = 0;
    rst_n = 1'b0; conv_start = 1'b0; conv_is_ref = 1'b0;
    cmp_pulse = 1'b0; win_len = 2'd0; ph_main = '0; ph_mid = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check("R1 result after reset", int'(result), 0);
    check("R1 strobe after reset", int'(result_valid), 0);

    // R8: reference is zero before any reference conversion
    run_conv(1'b0, 20, 0, 21, "R8 zero reference");

    // R2 R3 R4 R5 R8: every final phase code for every window length
    for (int wl = 0; wl < 4; wl++) begin
      set_ref(5, wl);
      for (int p = 1; p <= 40; p++) begin
        run_conv(1'b0, p, wl, cds_exp(p, wl), $sformatf("R3 R4 sweep wl=%0d p=%0d", wl, p));
      end
    end

    // R5: window length alone moves the code by its extra cycles
    set_ref(5, 0);
    run_conv(1'b0, 5, 3, 3, "R5 window offset");
    run_conv(1'b0, 5, 1, 1, "R5 short window");

    // R4 boundary and R6 saturation
    run_conv(1'b0, 4079, 0, cds_exp(4079, 0), "R4 top of coarse range");
    run_conv(1'b0, 4100, 0, cds_exp(4100, 0), "R6 saturated coarse");
    run_conv(1'b0, 4200, 2, cds_exp(4200, 2), "R6 saturated coarse wide window");

    // R9: restart right after a fall, then mid-window
    run_partial(12, 0);
    run_conv(1'b0, 7, 0, cds_exp(7, 0), "R9 restart after fall");
    run_partial(9, 3);
    run_conv(1'b0, 30, 1, cds_exp(30, 1), "R9 restart in window");

    // R8: clamp to zero below the reference
    set_ref(33, 2);
    run_conv(1'b0, 10, 2, 0, "R8 clamp");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule